// File: doc/BRIEF.md
# Bitwise Table-Lookup Logic Unit

This block evaluates an arbitrary Boolean function independently at every bit position of a word. Each bit of the result is read from a small truth table, and the bits at the same position in the source operands form the index. The unit serves as the execution stage for a family of "any logic function" operations. A ternary function takes its 8-entry table from an immediate. A binary function takes its 4-entry table from a nibble of a table register, so the function can change at run time. Two further modes apply the same lookups to a 4-bit condition field, and a per-bit write mask there decides which destination bits change.

Each operation is presented with a single-cycle `in_valid` strobe. The result and `out_valid` appear on the next clock edge. The result is held until the next strobe. Register-file access and instruction decode sit outside the block. The caller supplies the current destination value as `opnd_d`, because the ternary function uses it as a source and the masked modes fall back to it.

Top module: `bitlut_unit`

## Requirements
- R1: With `mode`=0 (word ternary), result bit i equals `imm8[{opnd_d[i], opnd_a[i], opnd_b[i]}]`. The index has `opnd_b` at bit 0, `opnd_a` at bit 1 and `opnd_d` at bit 2, and index 0 selects immediate bit 0.
- R2: With `mode`=1 (word binary), the table is `tbl_word[3:0]` when `nib_hi`=0 and `tbl_word[7:4]` when `nib_hi`=1. Result bit i equals `table[{opnd_a[i], opnd_b[i]}]`, with `opnd_b` at index bit 0.
- R3: With `mode`=2 (field ternary), each of the low four bit positions k for which `cf_mask[k]`=1 yields `imm8[{tbl_word[k], opnd_a[k], opnd_b[k]}]`.
- R4: With `mode`=3 (field binary), the field `tbl_word[3:0]` is the table, and each bit k for which `cf_mask[k]`=1 yields `tbl_word[{opnd_a[k], opnd_b[k]}]`.
- R5: In modes 2 and 3, each result bit k whose `cf_mask[k]`=0 equals `opnd_d[k]`, the previous destination bit.
- R6: In modes 2 and 3, result bits W-1 down to 4 are zero.
- R7: `out_valid` is high exactly in the cycle after an `in_valid` strobe. The result changes only on a strobe and holds its value otherwise.
- R8: While `rst` is high, `out_valid` and `result` are cleared to zero on the clock edge.
- R9: Two word-binary lookups using the low and high nibbles of an 8-bit table, merged by a word-ternary lookup with immediate 0xCA, give the same word as a single dynamic 3-input lookup of that table. For the merge, the low-nibble result goes to `opnd_b`, the high-nibble result goes to `opnd_a`, and the selector goes to `opnd_d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | 0 word ternary, 1 word binary, 2 field ternary, 3 field binary |
| nib_hi | input | 1 | Word-binary table nibble select (1 = bits 7:4) |
| cf_mask | input | 4 | Per-bit write mask for the field modes |
| opnd_a | input | W | First source (index bit 1) |
| opnd_b | input | W | Second source (index bit 0) |
| opnd_d | input | W | Current destination value (ternary index bit 2, masked fallback) |
| tbl_word | input | W | Table register; third field in the field modes |
| imm8 | input | 8 | Ternary truth table |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | W | Registered result word |

## Verification
The checker watches the strobe-to-valid timing on every cycle, along with result holding between strobes and the zero upper bits of the field modes. It also checks that a fully masked field operation returns the old destination bits. Two function-specific identities are checked on every cycle as well: a ternary table of 0xF0 copies the destination, and a binary table of 0b1010 copies the second operand. Whether the index is assembled in the right bit order for arbitrary tables can only be shown by the bench's vector table and pattern sweeps. The same holds for correct partial masks and for the equivalence of the two-binary-plus-merge sequence to a dynamic 3-input lookup.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;

  typedef enum logic [1:0] {
    MD_WORD_TERN = 2'd0,
    MD_WORD_BIN  = 2'd1,
    MD_CF_TERN   = 2'd2,
    MD_CF_BIN    = 2'd3
  } lut_mode_e;

  localparam int TBL3_BITS = 8;
  localparam int TBL2_BITS = 4;
  localparam int CF_BITS   = 4;

endpackage

// File: rtl/bitlut_nib_sel.sv
module bitlut_nib_sel #(
  parameter int W    = 64,
  parameter int NIBW = 4,
  parameter int NSEL = 2
) (
  input  logic [W-1:0]            tbl_word,
  input  logic [$clog2(NSEL)-1:0] sel,
  output logic [NIBW-1:0]         nib
);
  localparam int SELW = $clog2(NSEL);

  logic [NSEL-1:0][NIBW-1:0] cand;

  for (genvar n = 0; n < NSEL; n++) begin : g_cand
    assign cand[n] = tbl_word[n*NIBW +: NIBW];
  end

  always_comb begin
    nib = cand[0];
    for (int n = 0; n < NSEL; n++) begin
      if (sel == SELW'(n)) nib = cand[n];
    end
  end
endmodule

// File: rtl/bitlut_word_lane.sv
module bitlut_word_lane #(
  parameter int W = 64
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opd,
  input  logic [7:0]   tbl3,
  input  logic [3:0]   tbl2,
  input  logic         use_bin,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] idx3;
    logic [1:0] idx2;
    assign idx3 = {opd[i], opa[i], opb[i]};
    assign idx2 = {opa[i], opb[i]};
    assign y[i] = use_bin ? tbl2[idx2] : tbl3[idx3];
  end
endmodule

// File: rtl/bitlut_cf_unit.sv
module bitlut_cf_unit #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] fa,
  input  logic [FW-1:0] fb,
  input  logic [FW-1:0] fc,
  input  logic [FW-1:0] fprev,
  input  logic [FW-1:0] wmask,
  input  logic [7:0]    tbl3,
  input  logic          use_bin,
  output logic [FW-1:0] fout
);
  for (genvar k = 0; k < FW; k++) begin : g_fbit
    logic [2:0] idx3;
    logic [1:0] idx2;
    logic       lk;
    assign idx3 = {fc[k], fa[k], fb[k]};
    assign idx2 = {fa[k], fb[k]};
    assign lk   = use_bin ? fc[idx2] : tbl3[idx3];
    assign fout[k] = wmask[k] ? lk : fprev[k];
  end
endmodule

// File: rtl/bitlut_unit.sv
module bitlut_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   mode,
  input  logic         nib_hi,
  input  logic [3:0]   cf_mask,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_d,
  input  logic [W-1:0] tbl_word,
  input  logic [7:0]   imm8,
  output logic         out_valid,
  output logic [W-1:0] result
);
  import bitlut_pkg::*;

  localparam int FW = CF_BITS;

  lut_mode_e          md;
  logic [3:0]         word_tbl;
  logic [W-1:0]       word_y;
  logic [FW-1:0]      cf_y;
  logic [W-1:0]       nxt;

  assign md = lut_mode_e'(mode);

  bitlut_nib_sel #(.W(W), .NIBW(TBL2_BITS), .NSEL(2)) u_nsel (
    .tbl_word (tbl_word),
    .sel      (nib_hi),
    .nib      (word_tbl)
  );

  bitlut_word_lane #(.W(W)) u_word (
    .opa     (opnd_a),
    .opb     (opnd_b),
    .opd     (opnd_d),
    .tbl3    (imm8),
    .tbl2    (word_tbl),
    .use_bin (md == MD_WORD_BIN),
    .y       (word_y)
  );

  bitlut_cf_unit #(.FW(FW)) u_cf (
    .fa      (opnd_a[FW-1:0]),
    .fb      (opnd_b[FW-1:0]),
    .fc      (tbl_word[FW-1:0]),
    .fprev   (opnd_d[FW-1:0]),
    .wmask   (cf_mask),
    .tbl3    (imm8),
    .use_bin (md == MD_CF_BIN),
    .fout    (cf_y)
  );

  always_comb begin
    unique case (md)
      MD_WORD_TERN, MD_WORD_BIN: nxt = word_y;
      default:                   nxt = {{(W-FW){1'b0}}, cf_y};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/bitlut_unit_chk.sv
module bitlut_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   mode,
  input logic         nib_hi,
  input logic [3:0]   cf_mask,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] opnd_d,
  input logic [W-1:0] tbl_word,
  input logic [7:0]   imm8,
  input logic         out_valid,
  input logic [W-1:0] result
);
  logic [3:0] sel_nib;
  assign sel_nib = nib_hi ? tbl_word[7:4] : tbl_word[3:0];

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R6
  cf_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1]) |=> (result[W-1:4] == '0));

  // R5
  cf_full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1] && cf_mask == 4'b0000) |=> (result[3:0] == $past(opnd_d[3:0])));

  // R1
  tern_copy_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd0 && imm8 == 8'hF0) |=> (result == $past(opnd_d)));

  // R2
  bin_copy_b_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd1 && sel_nib == 4'b1010) |=> (result == $past(opnd_b)));
endmodule

bind bitlut_unit bitlut_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .nib_hi(nib_hi),
  .cf_mask(cf_mask), .opnd_b(opnd_b), .opnd_d(opnd_d), .tbl_word(tbl_word),
  .imm8(imm8), .out_valid(out_valid), .result(result)
);

// File: tb/sim_bitlut_unit.sv
`timescale 1ns/1ps
module sim_bitlut_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   mode;
  logic         nib_hi;
  logic [3:0]   cf_mask;
  logic [W-1:0] opnd_a, opnd_b, opnd_d, tbl_word;
  logic [7:0]   imm8;
  logic         out_valid;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bitlut_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .nib_hi(nib_hi),
    .cf_mask(cf_mask), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_d(opnd_d),
    .tbl_word(tbl_word), .imm8(imm8), .out_valid(out_valid), .result(result)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        nh;
    logic [3:0]  mk;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] d;
    logic [63:0] t;
    logic [7:0]  imm;
    logic [63:0] expv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1: 0xAA copies opnd_b
    '{2'd0, 1'b0, 4'h0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h00FF00FF00FF00FF, 64'h0, 8'hAA, 64'hFEDCBA9876543210},
    // R1: 0xCC copies opnd_a
    '{2'd0, 1'b0, 4'h0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h00FF00FF00FF00FF, 64'h0, 8'hCC, 64'h0123456789ABCDEF},
    // R1: 0x96 three-way xor
    '{2'd0, 1'b0, 4'h0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h00FF00FF00FF00FF, 64'h0, 8'h96, 64'hFF00FF00FF00FF00},
    // R1: 0xE8 majority
    '{2'd0, 1'b0, 4'h0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h00FF00FF00FF00FF, 64'h0, 8'hE8, 64'h00FF00FF00FF00FF},
    // R1: 0x80 three-way and
    '{2'd0, 1'b0, 4'h0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'hFFFFFFFFFFFFFFFF, 64'h0, 8'h80, 64'h0},
    // R2: low nibble 6 = xor
    '{2'd1, 1'b0, 4'h0, 64'hFFFF0000FFFF0000, 64'hFF00FF00FF00FF00, 64'h0, 64'h86, 8'h00, 64'h00FFFF0000FFFF00},
    // R2: high nibble 8 = and
    '{2'd1, 1'b1, 4'h0, 64'hFFFF0000FFFF0000, 64'hFF00FF00FF00FF00, 64'h0, 64'h86, 8'h00, 64'hFF000000FF000000},
    // R2: low nibble E = or
    '{2'd1, 1'b0, 4'h0, 64'hFFFF0000FFFF0000, 64'hFF00FF00FF00FF00, 64'h0, 64'h7E, 8'h00, 64'hFFFFFF00FFFFFF00},
    // R3 R6: field xor, full mask, upper operand bits ignored
    '{2'd2, 1'b0, 4'hF, 64'hFFFFFFFFFFFFFFFC, 64'hFFFFFFFFFFFFFFFA, 64'hFFFFFFFFFFFFFFF0, 64'hFFFFFFFFFFFFFFFF, 8'h96, 64'h9},
    // R3 R5: field xor, mask 0101, prev 0000
    '{2'd2, 1'b0, 4'h5, 64'hC, 64'hA, 64'h0, 64'hF, 8'h96, 64'h1},
    // R4 R5: field table 0110, mask 1100, prev 0011
    '{2'd3, 1'b0, 4'hC, 64'hAAAAAAAAAAAAAAAC, 64'hA, 64'h3, 64'h6, 8'hFF, 64'h7},
    // R4: field table 1000, full mask
    '{2'd3, 1'b0, 4'hF, 64'hC, 64'hA, 64'hF, 64'h8, 8'h00, 64'h8}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] md, input logic nh, input logic [3:0] mk,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d,
      input logic [W-1:0] t, input logic [7:0] imm);
    logic [W-1:0] r;
    logic [3:0] tb;
    r = '0;
    tb = nh ? t[7:4] : t[3:0];
    for (int i = 0; i < W; i++) begin
      if (md == 2'd0) r[i] = imm[4*d[i] + 2*a[i] + b[i]];
      else if (md == 2'd1) r[i] = tb[2*a[i] + b[i]];
      else if (i < 4) begin
        if (!mk[i]) r[i] = d[i];
        else if (md == 2'd2) r[i] = imm[4*t[i] + 2*a[i] + b[i]];
        else r[i] = t[2*a[i] + b[i]];
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [1:0] md, input logic nh, input logic [3:0] mk,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d,
      input logic [W-1:0] t, input logic [7:0] imm);
    @(negedge clk);
    mode = md; nib_hi = nh; cf_mask = mk;
    opnd_a = a; opnd_b = b; opnd_d = d; tbl_word = t; imm8 = imm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] lfsr(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[W-2] ^ s[W-4] ^ s[W-5]};
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] s, hold, x0, x1, sel, dyn, got;
    logic [7:0] tt;
    rst = 1'b1; in_valid = 1'b0; mode = '0; nib_hi = 1'b0; cf_mask = '0;
    opnd_a = '0; opnd_b = '0; opnd_d = '0; tbl_word = '0; imm8 = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R8 result", result, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].md, VECS[v].nh, VECS[v].mk, VECS[v].a, VECS[v].b,
            VECS[v].d, VECS[v].t, VECS[v].imm);
      chk($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", v), result, VECS[v].expv);
      chk("R7 out_valid after strobe", {63'd0, out_valid}, 64'd1);
    end

    // R7: result holds without a strobe while inputs change
    hold = result;
    opnd_a = ~opnd_a; opnd_b = ~opnd_b; imm8 = ~imm8; mode = 2'd0;
    @(negedge clk);
    chk("R7 hold result", result, hold);
    chk("R7 out_valid idle", {63'd0, out_valid}, 64'd0);

    // R1 R2 R3 R4 R5 R6: pattern sweep through every mode
    s = 64'h9E3779B97F4A7C15;
    for (int k = 0; k < 48; k++) begin
      logic [W-1:0] a, b, d, t;
      a = s; s = lfsr(s); b = s; s = lfsr(s); d = s; s = lfsr(s); t = s; s = lfsr(s);
      issue(2'(k), s[5], s[11:8], a, b, d, t, s[23:16]);
      chk($sformatf("R1/R2/R3/R4 sweep %0d mode %0d", k, k % 4), result,
          model(2'(k), s[5], s[11:8], a, b, d, t, s[23:16]));
    end

    // R9: two binary lookups merged by a ternary equal a dynamic 3-input lookup
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] a, b;
      a = s; s = lfsr(s); b = s; s = lfsr(s); sel = s; s = lfsr(s);
      tt = s[7:0]; s = lfsr(s);
      issue(2'd1, 1'b0, 4'h0, a, b, '0, {56'd0, tt}, 8'h00);
      x0 = result;
      issue(2'd1, 1'b1, 4'h0, a, b, '0, {56'd0, tt}, 8'h00);
      x1 = result;
      issue(2'd0, 1'b0, 4'h0, x1, x0, sel, '0, 8'hCA);
      got = result;
      for (int i = 0; i < W; i++) dyn[i] = tt[4*sel[i] + 2*a[i] + b[i]];
      chk($sformatf("R9 composed lookup %0d", k), got, dyn);
    end

    // R8: reset clears a nonzero result
    rst = 1'b1;
    @(negedge clk);
    chk("R8 result after reset", result, 64'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule